// File: doc/BRIEF.md
# Timer Compare Channels with Trigger Output

This block sits beside the counter of a general-purpose timer. It holds four compare channels. Each channel watches the shared counter value against its own compare value and drives a one-bit reference level. A 3-bit mode per channel sets how that level behaves: it can follow a PWM rule, be forced high or low, or be set, cleared or toggled when the counter reaches the compare value. Each channel also raises a sticky compare flag on a match when its interrupt enable is set.

A master selector forms one trigger line for other timers. A 3-bit master mode picks the source. It can be a level (the counter enable, or one channel's reference). It can also be a one-cycle pulse (a counter reset, an update event, or a match on channel 1). A channel that the master selector depends on keeps comparing even when its output and interrupt enables are both off.

Each channel reference is a two-state machine. The states are `REF_LO` and `REF_HI`. The transitions are named *force-low*, *force-high*, *match-set*, *match-clear*, *match-toggle*, *pwm-eval* and *update-preset*, and in every other case the state holds. The trigger pulse generator is also a two-state machine. Its states are `TP_IDLE` and `TP_FIRE`. It takes *fire* on the selected event and *expire* one cycle later. If the event is still present it takes *refire* instead.

Top module: `oc_trig_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, all references, all compare flags and the trigger output are 0 (master mode 0).
- R2: In channel mode 6 the reference becomes 1 on the clock after a cycle where counter < compare value, and 0 otherwise. Mode 7 gives the inverse. Both apply whether or not the channel is enabled.
- R3: Channel mode 4 drives the reference to 0 and mode 5 drives it to 1 on the next clock, whatever the counter does.
- R4: Mode 1 sets the reference on a match, mode 2 clears it and mode 3 inverts it. In mode 0, and in modes 1–3 between matches, the level holds, and it holds across counter wrap-around.
- R5: A match happens only in a cycle where the counter enable is 1, the counter differs from its value in the previous cycle, and it equals the compare value. A counter that stalls on the compare value gives one match only.
- R6: A channel with output enable 0, interrupt enable 0 and not selected by the master mode ignores matches.
- R7: Master mode 3 selects channel 1, and master mode 4+k selects channel k+1. A selected channel detects matches even with both of its enables off.
- R8: On an update pulse, a mode-6 channel goes to 1 and a mode-7 channel goes to 0 on the next clock, whatever the comparison gives.
- R9: A channel's compare flag sets on the clock after a match while its interrupt enable is 1. It stays set until its clear input is 1 in a cycle with no new match. A new match wins over a clear in the same cycle.
- R10: Master mode 1 makes the trigger equal to the counter enable in the same cycle. Master modes 4–7 make it equal to the reference of channels 1–4.
- R11: Master mode 0, 2 and 3 each give a trigger pulse on the clock after a counter-reset pulse, an update pulse, or a channel-1 match, in that order. Each event gives one cycle of trigger. In mode 3 this holds even when channel 1 is in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Shared counter value |
| cnt_en_i | input | 1 | Counter enable |
| upd_i | input | 1 | Update event pulse |
| cnt_rst_i | input | 1 | Counter reinitialisation pulse |
| cmp_i | input | 4*CW | Compare values, channel k in bits [k*CW +: CW] |
| mode_i | input | 12 | Channel modes, channel k in bits [3k +: 3] |
| oe_i | input | 4 | Per-channel output enable |
| ie_i | input | 4 | Per-channel interrupt enable |
| flag_clr_i | input | 4 | Per-channel flag clear |
| msel_i | input | 3 | Master mode |
| ref_o | output | 4 | Channel reference levels |
| flag_o | output | 4 | Sticky compare flags |
| trgo_o | output | 1 | Trigger output |

## Verification
A wrong reference state shows on `ref_o` on the clock after the faulty step. If that channel is selected, it also shows on `trgo_o` in the same cycle. In the latch modes the error does not go away by itself: it stays visible until the next match or a mode change. So a counter sweep over every compare value finds it within one counter period. A missed or doubled trigger pulse shows one cycle after the event. The bench sweeps a 4-bit counter over full periods, and in every cycle it compares all outputs against a model built from the requirements.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int OC_NCH = 4;

    typedef enum logic [2:0] {
        OC_FROZEN       = 3'd0,
        OC_SET_ON_MATCH = 3'd1,
        OC_CLR_ON_MATCH = 3'd2,
        OC_TOGGLE       = 3'd3,
        OC_FORCE_LO     = 3'd4,
        OC_FORCE_HI     = 3'd5,
        OC_PWM_A        = 3'd6,
        OC_PWM_B        = 3'd7
    } oc_mode_e;

    typedef enum logic [2:0] {
        MM_RST_PULSE = 3'd0,
        MM_EN_LEVEL  = 3'd1,
        MM_UPD_PULSE = 3'd2,
        MM_CH1_PULSE = 3'd3,
        MM_REF1      = 3'd4,
        MM_REF2      = 3'd5,
        MM_REF3      = 3'd6,
        MM_REF4      = 3'd7
    } mm_sel_e;

    typedef enum logic {
        REF_LO = 1'b0,
        REF_HI = 1'b1
    } ref_state_e;

    typedef enum logic {
        TP_IDLE = 1'b0,
        TP_FIRE = 1'b1
    } tp_state_e;

endpackage

// File: rtl/oc_step_det.sv
module oc_step_det #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          cnt_en_i,
    output logic          step_o
);

    logic [CW-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cnt_i;
    end

    assign step_o = cnt_en_i && (cnt_i != prev_q);

    // R5
    stall_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cnt_i) |-> !step_o);

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cmp_i,
    input  logic          step_i,
    input  logic          upd_i,
    input  logic [2:0]    mode_i,
    input  logic          active_i,
    input  logic          ie_i,
    input  logic          clr_i,
    output logic          ref_o,
    output logic          hit_o,
    output logic          flag_o
);

    ref_state_e st_q, st_d;
    oc_mode_e   mode;
    logic       below;
    logic       flag_q;

    assign mode  = oc_mode_e'(mode_i);
    assign below = (cnt_i < cmp_i);
    assign hit_o = step_i && active_i && (cnt_i == cmp_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= REF_LO;
        else        st_q <= st_d;
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (mode)
            OC_FROZEN:       st_d = st_q;
            OC_SET_ON_MATCH: if (hit_o) st_d = REF_HI;
            OC_CLR_ON_MATCH: if (hit_o) st_d = REF_LO;
            OC_TOGGLE:       if (hit_o) st_d = (st_q == REF_HI) ? REF_LO : REF_HI;
            OC_FORCE_LO:     st_d = REF_LO;
            OC_FORCE_HI:     st_d = REF_HI;
            OC_PWM_A:        st_d = (upd_i || below) ? REF_HI : REF_LO;
            OC_PWM_B:        st_d = (upd_i || below) ? REF_LO : REF_HI;
            default:         st_d = st_q;
        endcase
    end

    // outputs
    always_comb begin
        ref_o = (st_q == REF_HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (hit_o && ie_i)  flag_q <= 1'b1;
        else if (clr_i)          flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R3
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd5) |=> ref_o);
    // R3
    force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd4) |=> !ref_o);
    // R2
    pwm_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd6 && !upd_i) |=> (ref_o == $past(cnt_i < cmp_i)));
    // R8
    upd_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd7 && upd_i) |=> !ref_o);
    // R4
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0) |=> $stable(ref_o));
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && ie_i) |=> flag_o);
    // R6
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> !hit_o);

endmodule

// File: rtl/oc_trgo_sel.sv
module oc_trgo_sel
    import oc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        msel_i,
    input  logic              cnt_en_i,
    input  logic              rst_evt_i,
    input  logic              upd_i,
    input  logic              ch1_hit_i,
    input  logic [OC_NCH-1:0] ref_i,
    output logic [OC_NCH-1:0] sel_o,
    output logic              trgo_o
);

    mm_sel_e   msel;
    tp_state_e tp_q, tp_d;
    logic      fire;

    assign msel = mm_sel_e'(msel_i);

    for (genvar k = 0; k < OC_NCH; k++) begin : g_sel
        localparam logic [2:0] REF_CODE = 3'(4 + k);
        if (k == 0) begin : g_first
            assign sel_o[k] = (msel_i == REF_CODE) || (msel == MM_CH1_PULSE);
        end else begin : g_rest
            assign sel_o[k] = (msel_i == REF_CODE);
        end
    end

    always_comb begin
        fire = 1'b0;
        unique case (msel)
            MM_RST_PULSE: fire = rst_evt_i;
            MM_UPD_PULSE: fire = upd_i;
            MM_CH1_PULSE: fire = ch1_hit_i;
            default:      fire = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) tp_q <= TP_IDLE;
        else        tp_q <= tp_d;
    end

    always_comb begin
        tp_d = tp_q;
        unique case (tp_q)
            TP_IDLE: tp_d = fire ? TP_FIRE : TP_IDLE;
            TP_FIRE: tp_d = fire ? TP_FIRE : TP_IDLE;
            default: tp_d = TP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trgo_o = 1'b0;
        unique case (msel)
            MM_EN_LEVEL: trgo_o = cnt_en_i;
            MM_REF1:     trgo_o = ref_i[0];
            MM_REF2:     trgo_o = ref_i[1];
            MM_REF3:     trgo_o = ref_i[2];
            MM_REF4:     trgo_o = ref_i[3];
            default:     trgo_o = (tp_q == TP_FIRE);
        endcase
    end

    // R11
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msel_i == 3'd2 && upd_i) |=> (trgo_o || !$stable(msel_i)));
    // R11
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msel_i == 3'd0 && $stable(msel_i) && trgo_o && !$past(rst_evt_i, 2))
        |=> (!trgo_o || !$stable(msel_i) || $past(rst_evt_i)));
    // R10
    en_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msel_i == 3'd1) |-> (trgo_o == cnt_en_i));
    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

endmodule

// File: rtl/oc_trig_unit.sv
module oc_trig_unit
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        cnt_i,
    input  logic                 cnt_en_i,
    input  logic                 upd_i,
    input  logic                 cnt_rst_i,
    input  logic [4*CW-1:0]      cmp_i,
    input  logic [11:0]          mode_i,
    input  logic [3:0]           oe_i,
    input  logic [3:0]           ie_i,
    input  logic [3:0]           flag_clr_i,
    input  logic [2:0]           msel_i,
    output logic [3:0]           ref_o,
    output logic [3:0]           flag_o,
    output logic                 trgo_o
);

    localparam int MW = 3;

    logic              step;
    logic [OC_NCH-1:0] sel;
    logic [OC_NCH-1:0] hit;
    logic [OC_NCH-1:0] refs;

    oc_step_det #(.CW(CW)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt_i),
        .cnt_en_i (cnt_en_i),
        .step_o   (step)
    );

    for (genvar k = 0; k < OC_NCH; k++) begin : g_ch
        oc_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_i    (cnt_i),
            .cmp_i    (cmp_i[k*CW +: CW]),
            .step_i   (step),
            .upd_i    (upd_i),
            .mode_i   (mode_i[k*MW +: MW]),
            .active_i (oe_i[k] | ie_i[k] | sel[k]),
            .ie_i     (ie_i[k]),
            .clr_i    (flag_clr_i[k]),
            .ref_o    (refs[k]),
            .hit_o    (hit[k]),
            .flag_o   (flag_o[k])
        );
    end

    oc_trgo_sel u_trgo (
        .clk       (clk),
        .rst_n     (rst_n),
        .msel_i    (msel_i),
        .cnt_en_i  (cnt_en_i),
        .rst_evt_i (cnt_rst_i),
        .upd_i     (upd_i),
        .ch1_hit_i (hit[0]),
        .ref_i     (refs),
        .sel_o     (sel),
        .trgo_o    (trgo_o)
    );

    assign ref_o = refs;

    // R7
    ch1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msel_i == 3'd3 && cnt_en_i && cnt_i == cmp_i[CW-1:0] && !$stable(cnt_i))
        |=> (trgo_o || !$stable(msel_i)));

endmodule

// File: tb/tb_oc_trig_unit.sv
`timescale 1ns/1ps
module tb_oc_trig_unit;

    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [CW-1:0]   cnt;
    logic            en, upd, rstev;
    logic [CW-1:0]   cmp [4];
    logic [2:0]      mode [4];
    logic [3:0]      oe, ie, clr;
    logic [2:0]      msel;
    logic [4*CW-1:0] cmp_bus;
    logic [11:0]     mode_bus;
    logic [3:0]      ref_w, flag_w;
    logic            trgo_w;

    logic [3:0]      e_ref, e_flag;
    logic            e_pulse;
    logic [CW-1:0]   pcnt;
    int              checks = 0;
    int              errors = 0;

    always #2.5 clk = ~clk;

    for (genvar k = 0; k < 4; k++) begin : g_pack
        assign cmp_bus[k*CW +: CW] = cmp[k];
        assign mode_bus[k*3 +: 3]  = mode[k];
    end

    oc_trig_unit #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_en_i(en), .upd_i(upd),
        .cnt_rst_i(rstev), .cmp_i(cmp_bus), .mode_i(mode_bus), .oe_i(oe),
        .ie_i(ie), .flag_clr_i(clr), .msel_i(msel),
        .ref_o(ref_w), .flag_o(flag_w), .trgo_o(trgo_w)
    );

    task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_trgo();
        if (msel == 3'd1) return en;
        if (msel >= 3'd4) return e_ref[msel - 3'd4];
        return e_pulse;
    endfunction

    // one clock: model next state from current inputs, then compare after edge
    task automatic tick(input string tag);
        logic step;
        logic [3:0] m;
        step = en && (cnt != pcnt);
        for (int k = 0; k < 4; k++) begin
            logic act;
            logic below;
            act = oe[k] | ie[k] | ((msel == 3'd3) && k == 0) | (msel == 3'(4 + k));
            m[k] = step && act && (cnt == cmp[k]);
            below = cnt < cmp[k];
            case (mode[k])
                3'd1: if (m[k]) e_ref[k] = 1'b1;
                3'd2: if (m[k]) e_ref[k] = 1'b0;
                3'd3: if (m[k]) e_ref[k] = ~e_ref[k];
                3'd4: e_ref[k] = 1'b0;
                3'd5: e_ref[k] = 1'b1;
                3'd6: e_ref[k] = upd | below;
                3'd7: e_ref[k] = !(upd | below);
                default: ;
            endcase
            if (m[k] && ie[k]) e_flag[k] = 1'b1;
            else if (clr[k])   e_flag[k] = 1'b0;
        end
        e_pulse = (msel == 3'd0) ? rstev : (msel == 3'd2) ? upd : (msel == 3'd3) ? m[0] : 1'b0;
        pcnt = cnt;
        @(posedge clk);
        #1;
        chk(tag, "ref", ref_w, e_ref);
        chk(tag, "flag", flag_w, e_flag);
        chk(tag, "trgo", {3'b0, trgo_w}, {3'b0, exp_trgo()});
        @(negedge clk);
    endtask

    task automatic sweep(input string tag, input int periods);
        for (int p = 0; p < periods * 16; p++) begin
            cnt = CW'(p);
            tick(tag);
        end
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt = '0; en = 1'b0; upd = 1'b0; rstev = 1'b0;
        oe = '0; ie = '0; clr = '0; msel = 3'd0;
        for (int k = 0; k < 4; k++) begin cmp[k] = '0; mode[k] = 3'd5; end
        e_ref = '0; e_flag = '0; e_pulse = 1'b0; pcnt = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state even with force-high requested
        chk("R1", "ref", ref_w, 4'b0);
        chk("R1", "flag", flag_w, 4'b0);
        chk("R1", "trgo", {3'b0, trgo_w}, 4'b0);
        @(negedge clk);
        for (int k = 0; k < 4; k++) mode[k] = 3'd0;
        rst_n = 1'b1;
        tick("R1");

        // R2 / R10: PWM sweep over all compare values, every reference selected in turn
        en = 1'b1;
        for (int c = 0; c < 16; c++) begin
            cmp[0] = CW'(c); cmp[1] = CW'(15 - c); cmp[2] = CW'(c); cmp[3] = CW'((c * 5) % 16);
            mode[0] = 3'd6; mode[1] = 3'd6; mode[2] = 3'd7; mode[3] = 3'd7;
            msel = 3'(4 + (c % 4));
            sweep("R2", 1);
        end
        msel = 3'd1;
        en = 1'b0; tick("R10");
        en = 1'b1; tick("R10");

        // R3: force modes while the counter runs
        mode[0] = 3'd5; mode[1] = 3'd4; mode[2] = 3'd5; mode[3] = 3'd4;
        sweep("R3", 1);
        mode[0] = 3'd4; mode[1] = 3'd5;
        sweep("R3", 1);

        // R4: latch modes across wraps, every compare value
        oe = 4'hF;
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 4; k++) cmp[k] = CW'((c + 4 * k) % 16);
            mode[0] = 3'd1; mode[1] = 3'd2; mode[2] = 3'd3; mode[3] = 3'd0;
            msel = 3'd4;
            sweep("R4", 2);
            mode[0] = 3'd6; tick("R4"); // switch back to PWM re-evaluates
            mode[1] = 3'd5; tick("R4");
        end

        // R5: counter stalls on compare value, and counter disabled
        mode[2] = 3'd3; cmp[2] = 4'd7; msel = 3'd6;
        cnt = 4'd6; tick("R5");
        cnt = 4'd7; tick("R5");
        repeat (4) tick("R5");
        en = 1'b0; cnt = 4'd8; tick("R5"); cnt = 4'd7; tick("R5");
        en = 1'b1;

        // R6 / R7: disabled channel ignores matches unless selected
        oe = 4'h0; ie = 4'h0; msel = 3'd1;
        for (int k = 0; k < 4; k++) begin mode[k] = 3'd4; cmp[k] = 4'd5; end
        tick("R6");
        for (int k = 0; k < 4; k++) mode[k] = 3'd1;
        sweep("R6", 1);
        for (int k = 0; k < 4; k++) begin
            msel = 3'(4 + k);
            sweep("R7", 1);
        end

        // R8: update presets PWM levels
        for (int k = 0; k < 4; k++) cmp[k] = 4'd3;
        mode[0] = 3'd6; mode[1] = 3'd7; mode[2] = 3'd6; mode[3] = 3'd7;
        msel = 3'd4;
        cnt = 4'd12; tick("R8");
        upd = 1'b1; tick("R8");
        upd = 1'b0; tick("R8");
        msel = 3'd5; upd = 1'b1; tick("R8"); upd = 1'b0; tick("R8");

        // R9: flags set, hold, clear, match beats clear
        ie = 4'b0101; mode[0] = 3'd0; mode[2] = 3'd0;
        cmp[0] = 4'd2; cmp[2] = 4'd9;
        sweep("R9", 1);
        clr = 4'b0001; tick("R9"); clr = 4'b0;
        cnt = 4'd8; tick("R9");
        clr = 4'b0100; cnt = 4'd9; tick("R9");
        clr = 4'b0100; cnt = 4'd10; tick("R9");
        clr = 4'b0; ie = 4'b0;

        // R11: pulse modes, channel 1 frozen in mode 3
        mode[0] = 3'd0; cmp[0] = 4'd4;
        msel = 3'd3; sweep("R11", 2);
        msel = 3'd0;
        rstev = 1'b1; tick("R11"); rstev = 1'b0; tick("R11"); tick("R11");
        rstev = 1'b1; tick("R11"); tick("R11"); rstev = 1'b0; tick("R11");
        msel = 3'd2;
        upd = 1'b1; tick("R11"); upd = 1'b0; tick("R11");
        rstev = 1'b1; tick("R11"); rstev = 1'b0; tick("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule